// File: doc/BRIEF.md
# Voltmeter Digit Display Formatter

This block turns an 8-bit conversion code into three lit seven-segment digits that read a voltage in volts with two decimal places. The code is doubled by a one-bit left shift, giving a 9-bit count from 0 to 510. One count of that value is one hundredth of a volt, so the largest code shows as 5.10. The count is split into hundreds, tens and units BCD digits by a chain of conditional add-3 cells. Each digit then feeds its own decoder. The decimal point is lit on the hundreds digit only.

Codes arrive on a valid/ready stream and are held in a single output stage. `in_ready` is high whenever the stage is empty, or when its held reading is being taken in the same cycle. A code is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. It is shown from the next cycle, with `out_valid` high, and stays unchanged until a cycle in which `out_ready` is high. While nothing is held, every segment and the decimal point are dark. The conversion and the decoding themselves are combinational and work from the held code.

The analog scaling happens outside the block. A divider of about 0.979 ahead of the converter makes the doubled count approximately equal to 100 times the measured voltage.

Top module: `voltfmt_top`

## Requirements
- R1: While `out_valid` is high, the three digits show the decimal hundreds, tens and units of twice the held code. Digit 0 is units, digit 1 is tens and digit 2 is hundreds.
- R2: Each digit occupies `seg_o[7*i+6:7*i]` with bit order {g,f,e,d,c,b,a}, active high. The patterns are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R3: While `out_valid` is high, `dp_o` is 3'b100, so the point is lit on the hundreds digit only.
- R4: The hundreds digit never shows more than 5. Code 255 shows 5, 1, 0.
- R5: `in_ready` equals (!`out_valid` || `out_ready`). A code taken on an edge is shown with `out_valid` high in the following cycle.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and holds the segments and the point unchanged.
- R7: When the held reading is taken and no new code is accepted, `out_valid` is low in the next cycle.
- R8: After reset, and whenever `out_valid` is low, `seg_o` and `dp_o` are all zero.
- R9: When a held reading is taken and a new code is accepted on the same edge, `out_valid` stays high and the new code is shown in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A conversion code is offered |
| in_ready | output | 1 | The block accepts the offered code this cycle |
| in_code | input | 8 | Raw conversion code |
| out_valid | output | 1 | A reading is on the digit outputs |
| out_ready | input | 1 | The consumer takes the shown reading this cycle |
| seg_o | output | 21 | Segment lines, 7 per digit, units in the low bits |
| dp_o | output | 3 | Decimal point per digit |

## Verification
Taking the shown reading and accepting a new code can happen on the same edge. A back-to-back phase provokes this by holding `in_valid` and `out_ready` high across half of the code sweep. In that phase, each next cycle must keep `out_valid` high and show the new code's digits, with no dark cycle in between. The other phases use stall patterns to cover holding and draining: a stalled reading must be unchanged in the next cycle, and a drained stage must go dark. A behavioural model in the bench checks all of this on every clock, computing the digits by integer division of twice the code.

// File: rtl/voltfmt_pkg.sv
package voltfmt_pkg;
  localparam int SEG_W = 7;
  typedef logic [3:0]       bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  function automatic bcd_t cadd3(input bcd_t x);
    return (x >= 4'd5) ? bcd_t'(x + 4'd3) : x;
  endfunction
endpackage

// File: rtl/voltfmt_bin2bcd.sv
module voltfmt_bin2bcd #(
  parameter int IN_W   = 9,
  parameter int DIGITS = 3
) (
  input  logic [IN_W-1:0]     bin,
  output logic [4*DIGITS-1:0] bcd
);
  import voltfmt_pkg::*;
  localparam int BW = 4 * DIGITS;

  logic [BW-1:0] stage [0:IN_W];
  assign stage[0] = '0;

  for (genvar s = 0; s < IN_W; s++) begin : g_step
    logic [BW-1:0] adj;
    for (genvar d = 0; d < DIGITS; d++) begin : g_cell
      assign adj[4*d +: 4] = cadd3(stage[s][4*d +: 4]);
    end
    assign stage[s+1] = {adj[BW-2:0], bin[IN_W-1-s]};
  end

  assign bcd = stage[IN_W];
endmodule

// File: rtl/voltfmt_seg7.sv
module voltfmt_seg7 (
  input  voltfmt_pkg::bcd_t digit,
  input  logic              en,
  output voltfmt_pkg::seg_t seg
);
  import voltfmt_pkg::*;
  seg_t pat;
  always_comb begin
    unique case (digit)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = 7'h00;
    endcase
  end
  assign seg = en ? pat : '0;
endmodule

// File: rtl/voltfmt_hold.sv
module voltfmt_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/voltfmt_top.sv
module voltfmt_top #(
  parameter int CODE_W = 8,
  parameter int DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CODE_W-1:0]     in_code,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7*DIGITS-1:0]   seg_o,
  output logic [DIGITS-1:0]     dp_o
);
  import voltfmt_pkg::*;
  localparam int DBL_W = CODE_W + 1;

  logic [CODE_W-1:0]   held_code;
  logic [DBL_W-1:0]    doubled;
  logic [4*DIGITS-1:0] bcd;

  voltfmt_hold #(.W(CODE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_code),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (held_code)
  );

  assign doubled = {held_code, 1'b0};

  voltfmt_bin2bcd #(.IN_W(DBL_W), .DIGITS(DIGITS)) u_bcd (
    .bin(doubled),
    .bcd(bcd)
  );

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    voltfmt_seg7 u_dec (
      .digit(bcd[4*i +: 4]),
      .en   (out_valid),
      .seg  (seg_o[7*i +: 7])
    );
    assign dp_o[i] = out_valid && (i == DIGITS - 1);
  end
endmodule

// File: rtl/voltfmt_chk.sv
module voltfmt_chk #(
  parameter int CODE_W = 8,
  parameter int DIGITS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [7*DIGITS-1:0] seg_o,
  input logic [DIGITS-1:0]   dp_o
);
  logic [6:0] hund;
  assign hund = seg_o[7*(DIGITS-1) +: 7];

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(seg_o) && $stable(dp_o)); // R6
  AST_DRAIN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R7
  AST_POINT_HUNDREDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dp_o == DIGITS'(1 << (DIGITS-1))); // R3
  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> seg_o == '0 && dp_o == '0); // R8
  AST_HUNDREDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hund inside {7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D}); // R4
  AST_SWAP_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && in_valid |=> out_valid); // R9
endmodule

bind voltfmt_top voltfmt_chk #(.CODE_W(CODE_W), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .seg_o(seg_o), .dp_o(dp_o)
);

// File: tb/voltfmt_top_tb.sv
module voltfmt_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [20:0] seg_o;
  logic [2:0]  dp_o;

  int tests = 0;
  int fails = 0;

  voltfmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .seg_o(seg_o), .dp_o(dp_o)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] pat_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [20:0] exp_seg(input int code);
    int v;
    v = 2 * code;
    return {pat_of(v / 100), pat_of((v / 10) % 10), pat_of(v % 10)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // model state
  int    mv = 0, mc = 0, next_idx = 0, cyc = 0;
  string ctx = "R1 R2";
  bit    done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", 32'(out_valid), 0);
    check("R8 reset seg", 32'(seg_o), 0);
    check("R8 reset dp", 32'(dp_o), 0);
    rst_n = 1'b1;
    while (next_idx < 256 || mv != 0) begin
      int fin, fout;
      @(negedge clk);
      // compare outputs with model
      if (mv != 0) begin
        check(ctx, 32'(seg_o), 32'(exp_seg(mc)));
        check("R3 point", 32'(dp_o), 32'h4);
        if (mc == 255) check("R4 top code", 32'(seg_o), 32'({pat_of(5), pat_of(1), pat_of(0)}));
      end else begin
        check("R8 idle seg", 32'(seg_o), 0);
        check("R8 idle dp", 32'(dp_o), 0);
      end
      check((ctx == "R7") ? "R7 drain" : "R5 valid", 32'(out_valid), 32'(mv));
      // choose next inputs
      if (next_idx >= 256) begin
        in_valid  = 1'b0;
        out_ready = 1'b1;
      end else if (next_idx < 128) begin
        in_valid  = (cyc % 3) != 1;
        out_ready = (cyc % 5) >= 2;
      end else begin
        in_valid  = 1'b1;
        out_ready = 1'b1;
      end
      in_code = 8'(next_idx);
      #1;
      check("R5 ready", 32'(in_ready), 32'((mv == 0) || out_ready));
      fin  = (in_valid && ((mv == 0) || out_ready)) ? 1 : 0;
      fout = (mv != 0 && out_ready) ? 1 : 0;
      if (mv != 0 && !out_ready)       ctx = "R6";
      else if (fin != 0 && fout != 0)  ctx = "R9";
      else if (fout != 0 && fin == 0)  ctx = "R7";
      else                             ctx = "R1 R2";
      if (fin != 0) begin
        mv = 1; mc = next_idx; next_idx++;
      end else if (fout != 0) begin
        mv = 0;
      end
      cyc++;
    end
    @(negedge clk);
    check("R7 final dark", 32'(out_valid), 0);
    check("R8 final seg", 32'(seg_o), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule